// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This engine carries out one of two drawing operations on a frame buffer addressed in bytes: painting a rectangle with a solid colour, or moving a rectangle of pixels from one place on the screen to another. A client loads the operation, the source and destination corners, the width, the height and the colour onto the inputs and raises `start` for one cycle. The screen width in pixels and the pixel size in bytes are also sampled at that moment.

The engine then works through the rectangle row by row over a synchronous byte-wide memory port. Read data returns one cycle after a read strobe. A copy reads each byte and writes it in the following cycle. The engine chooses the row order and the byte order so that source and destination may overlap in any direction. A fill writes one byte per cycle. It steps through the low bytes of the colour word, restarting with a period equal to the pixel size.

When the rectangle is done, the engine holds a dirty-rectangle record with the destination coordinates and size. The record stays valid until the consumer takes it. The engine is busy for the whole of that span.

Top module: `rect_blit`

## Requirements
- R1: While reset is held and after its release, `busy`, `mem_rd`, `mem_wr` and `dirty_valid` are low until a start pulse is taken.
- R2: A fill writes byte `c` of every destination row at address `bpp*dst_x + bpp*scr_w*(dst_y+row) + c`, for `c` from 0 to `bpp*rect_w-1`. The byte written is `colour[8*(c mod bpp) +: 8]`, so byte 0 of the colour is bits 7:0, and exactly `bpp*rect_w*rect_h` writes occur.
- R3: After a copy (`op_copy`=1), every destination byte holds the value that the matching source byte had before the operation began, including when the two rectangles overlap.
- R4: When `dst_y` > `src_y`, a copy processes rows bottom-up, and its first write lands in destination row `dst_y+rect_h-1`. Otherwise rows go top-down, and the first write lands in row `dst_y`.
- R5: A copy with `dst_x` > `src_x` moves each row from its rightmost byte towards its leftmost. Otherwise it moves each row from left to right.
- R6: An operation with `rect_h`=0 or `rect_w`=0 performs no memory access but still produces its dirty record.
- R7: On completion `dirty_valid` rises with `dirty_x`/`dirty_y`/`dirty_w`/`dirty_h` equal to the destination x, y, width and height. The record is held stable until `dirty_ready`. `busy` stays high from the accepted start pulse until the record is taken, and falls in the next cycle.
- R8: Start pulses that arrive while `busy` is high are ignored and change neither memory nor the record.
- R9: At most one of `mem_rd` and `mem_wr` is high in any cycle, and neither is high unless the engine is busy and has no record pending.
- R10: Pixel sizes (`bpp`) of 1, 2, 3 and 4 bytes are all handled by R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_copy | input | 1 | 1 = copy, 0 = solid fill |
| src_x | input | XW | Source left column in pixels |
| src_y | input | XW | Source top row |
| dst_x | input | XW | Destination left column in pixels |
| dst_y | input | XW | Destination top row |
| rect_w | input | XW | Width in pixels |
| rect_h | input | XW | Height in rows |
| colour | input | 32 | Fill colour, byte 0 in bits 7:0 |
| scr_w | input | XW | Screen width in pixels |
| bpp | input | 3 | Bytes per pixel, 1 to 4 |
| busy | output | 1 | Operation in progress or record pending |
| mem_addr | output | AW | Byte address |
| mem_rd | output | 1 | Read strobe, data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| dirty_valid | output | 1 | Dirty record valid |
| dirty_ready | input | 1 | Dirty record taken |
| dirty_x | output | XW | Dirty rectangle x |
| dirty_y | output | XW | Dirty rectangle y |
| dirty_w | output | XW | Dirty rectangle width |
| dirty_h | output | XW | Dirty rectangle height |

## Verification
The bench keeps the default coordinate width of 12 and address width of 20 bits. It uses a 16 by 16 pixel screen backed by a 1024-byte memory model, which is large enough for every pixel size from 1 to 4 bytes. At that screen size, rectangles of up to six pixels on a side overlap often, so random copies regularly exercise the upward, downward and same-row move cases against a snapshot model. Directed cases pin the first write address for each ordering, the colour byte cycle at three bytes per pixel, empty rectangles and starts issued while busy.

// File: rtl/rect_blit.sv
module rect_blit #(
  parameter int XW = 12,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_copy,
  input  logic [XW-1:0] src_x,
  input  logic [XW-1:0] src_y,
  input  logic [XW-1:0] dst_x,
  input  logic [XW-1:0] dst_y,
  input  logic [XW-1:0] rect_w,
  input  logic [XW-1:0] rect_h,
  input  logic [31:0]   colour,
  input  logic [XW-1:0] scr_w,
  input  logic [2:0]    bpp,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          dirty_valid,
  input  logic          dirty_ready,
  output logic [XW-1:0] dirty_x,
  output logic [XW-1:0] dirty_y,
  output logic [XW-1:0] dirty_w,
  output logic [XW-1:0] dirty_h
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} state_t;

  state_t        st;
  logic          cp_q;
  logic [XW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q, pw_q, row_q;
  logic [31:0]   col_q;
  logic [2:0]    bpp_q;
  logic [AW-1:0] byte_q;
  logic [1:0]    ph_q;

  logic [AW-1:0] bpp_a, pitch, row_len, row_i, col_i, src_a, dst_a;
  logic          bottom_up, right_left, last_byte, last_row;

  assign bpp_a      = AW'(bpp_q);
  assign pitch      = bpp_a * AW'(pw_q);
  assign row_len    = bpp_a * AW'(w_q);
  assign bottom_up  = cp_q && (dy_q > sy_q);
  assign right_left = cp_q && (dx_q > sx_q);
  assign row_i      = bottom_up ? AW'(h_q) - AW'(1) - AW'(row_q) : AW'(row_q);
  assign col_i      = right_left ? row_len - AW'(1) - byte_q : byte_q;
  assign src_a      = bpp_a * AW'(sx_q) + pitch * (AW'(sy_q) + row_i) + col_i;
  assign dst_a      = bpp_a * AW'(dx_q) + pitch * (AW'(dy_q) + row_i) + col_i;
  assign last_byte  = byte_q == row_len - AW'(1);
  assign last_row   = row_q == h_q - XW'(1);

  assign busy        = st != S_IDLE;
  assign mem_rd      = st == S_RD;
  assign mem_wr      = st == S_WR;
  assign mem_addr    = (st == S_RD) ? src_a : dst_a;
  assign mem_wdata   = cp_q ? mem_rdata : col_q[8*ph_q +: 8];
  assign dirty_valid = st == S_DONE;
  assign dirty_x     = dx_q;
  assign dirty_y     = dy_q;
  assign dirty_w     = w_q;
  assign dirty_h     = h_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cp_q   <= 1'b0;
      sx_q   <= '0;
      sy_q   <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      pw_q   <= '0;
      col_q  <= '0;
      bpp_q  <= 3'd1;
      row_q  <= '0;
      byte_q <= '0;
      ph_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cp_q   <= op_copy;
          sx_q   <= src_x;
          sy_q   <= src_y;
          dx_q   <= dst_x;
          dy_q   <= dst_y;
          w_q    <= rect_w;
          h_q    <= rect_h;
          pw_q   <= scr_w;
          col_q  <= colour;
          bpp_q  <= bpp;
          row_q  <= '0;
          byte_q <= '0;
          ph_q   <= '0;
          if (rect_w == '0 || rect_h == '0) st <= S_DONE;
          else st <= op_copy ? S_RD : S_WR;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          st <= cp_q ? S_RD : S_WR;
          if (last_byte) begin
            byte_q <= '0;
            ph_q   <= '0;
            if (last_row) st <= S_DONE;
            else row_q <= row_q + XW'(1);
          end else begin
            byte_q <= byte_q + AW'(1);
            ph_q   <= ({1'b0, ph_q} == bpp_q - 3'd1) ? 2'd0 : ph_q + 2'd1;
          end
        end
        S_DONE: if (dirty_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rect_blit_chk.sv
module rect_blit_chk #(
  parameter int XW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          dirty_valid,
  input logic          dirty_ready,
  input logic [XW-1:0] dirty_x,
  input logic [XW-1:0] dirty_y,
  input logic [XW-1:0] dirty_w,
  input logic [XW-1:0] dirty_h
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !dirty_valid));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_access_in_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (busy && !dirty_valid));

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  assert_record_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_valid && !dirty_ready) |=> (dirty_valid && $stable(dirty_x) &&
      $stable(dirty_y) && $stable(dirty_w) && $stable(dirty_h)));

  assert_busy_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(dirty_valid && dirty_ready)) |=> busy);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_valid && dirty_ready) |=> !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dirty_valid && !dirty_ready) |=> dirty_valid);

endmodule

bind rect_blit rect_blit_chk #(.XW(XW)) u_chk (.*);

// File: tb/rect_blit_bench.sv
module rect_blit_bench;
  localparam int CLK_NS = 10;
  localparam int XW = 12;
  localparam int AW = 20;
  localparam int SW = 16;
  localparam int SH = 16;
  localparam int MEM = 4 * SW * SH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_copy = 1'b0, dirty_ready = 1'b0;
  logic [XW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic [XW-1:0] scr_w = XW'(SW);
  logic [31:0] colour = '0;
  logic [2:0] bpp = 3'd1;
  logic busy, mem_rd, mem_wr, dirty_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [XW-1:0] dirty_x, dirty_y, dirty_w, dirty_h;

  logic [7:0] mem [MEM];
  logic [7:0] snap [MEM];
  logic [7:0] expm [MEM];
  logic tb_we = 1'b0;
  int tb_wa = 0;
  logic [7:0] tb_wd = '0;
  int wcnt = 0, arm = 0, first_wa = -1;
  int total = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  rect_blit #(.XW(XW), .AW(AW)) u_rect_blit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_copy(op_copy),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rect_w(rect_w), .rect_h(rect_h), .colour(colour), .scr_w(scr_w), .bpp(bpp),
    .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dirty_valid(dirty_valid),
    .dirty_ready(dirty_ready), .dirty_x(dirty_x), .dirty_y(dirty_y),
    .dirty_w(dirty_w), .dirty_h(dirty_h));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr % MEM];
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_wr) begin
      mem[mem_addr % MEM] <= mem_wdata;
      if (wcnt == arm) first_wa <= int'(mem_addr);
      wcnt <= wcnt + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic run_op(bit cp, int sx, int sy, int dx, int dy, int w, int h,
                        logic [31:0] col, int bp, int exp_first, string tag, bit inject);
    int base, bad, bad_at;
    for (int i = 0; i < MEM; i++) begin snap[i] = mem[i]; expm[i] = mem[i]; end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < bp*w; c++) begin
        int da = bp*dx + bp*SW*(dy+r) + c;
        if (cp) expm[da] = snap[bp*sx + bp*SW*(sy+r) + c];
        else expm[da] = col[8*(c % bp) +: 8];
      end
    base = wcnt;
    arm = wcnt;
    @(negedge clk);
    op_copy = cp; src_x = XW'(sx); src_y = XW'(sy); dst_x = XW'(dx); dst_y = XW'(dy);
    rect_w = XW'(w); rect_h = XW'(h); colour = col; bpp = 3'(bp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", {tag, " busy after start"}, int'(busy), 1);
    if (inject) begin
      op_copy = 1'b0; dst_x = 0; dst_y = 0; rect_w = 5; rect_h = 5; colour = 32'hA5A5A5A5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!dirty_valid) @(negedge clk);
    check(int'(dirty_x) == dx && int'(dirty_y) == dy && int'(dirty_w) == w && int'(dirty_h) == h,
          "R7", {tag, " record x"}, int'(dirty_x), dx);
    check(wcnt - base == bp*w*h, (w == 0 || h == 0) ? "R6" : "R2",
          {tag, " write count"}, wcnt - base, bp*w*h);
    bad = 0; bad_at = -1;
    for (int i = 0; i < MEM; i++)
      if (mem[i] !== expm[i]) begin bad++; if (bad_at < 0) bad_at = i; end
    check(bad == 0, cp ? "R3" : "R2", {tag, " memory mismatches"}, bad, 0);
    if (bad != 0) $display("  first mismatch at %0d", bad_at);
    if (exp_first >= 0)
      check(first_wa == exp_first, cp ? ((sy != dy) ? "R4" : "R5") : "R2",
            {tag, " first write address"}, first_wa, exp_first);
    dirty_ready = 1'b1;
    @(negedge clk);
    dirty_ready = 1'b0;
    check(busy == 1'b0 && dirty_valid == 1'b0, "R7", {tag, " released"}, int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < MEM; i++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_wa = i; tb_wd = 8'($urandom);
    end
    @(negedge clk);
    tb_we = 1'b0;
    check(!busy && !mem_rd && !mem_wr && !dirty_valid, "R1", "quiet in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !mem_wr && !dirty_valid, "R1", "quiet after reset", int'(mem_wr), 0);

    run_op(0, 0, 0, 2, 1, 4, 2, 32'h11223344, 3, 54, "fill bpp3", 0);
    check(mem[54] == 8'h44 && mem[55] == 8'h33 && mem[56] == 8'h22 && mem[57] == 8'h44,
          "R2", "colour byte cycle", int'(mem[57]), 'h44);
    run_op(1, 1, 2, 1, 3, 5, 4, 0, 2, 194, "copy down R4", 0);
    run_op(1, 3, 5, 3, 3, 4, 4, 0, 1, 51, "copy up R4", 0);
    run_op(1, 1, 7, 3, 7, 5, 1, 0, 4, 479, "row right R5", 0);
    run_op(1, 4, 9, 2, 9, 6, 1, 0, 3, 3*2 + 48*9, "row left R5", 0);
    run_op(0, 0, 0, 5, 5, 3, 0, 32'hDEADBEEF, 2, -1, "zero height R6", 0);
    run_op(1, 2, 2, 6, 6, 0, 3, 0, 4, -1, "zero width R6", 0);
    run_op(0, 0, 0, 8, 8, 3, 3, 32'h00C0FFEE, 4, -1, "busy start R8", 1);
    run_op(1, 0, 0, 9, 2, 4, 4, 0, 1, -1, "copy busy start R8", 1);

    for (int k = 0; k < 40; k++) begin
      int bp, w, h, sx, sy, dx, dy;
      bit cp;
      bp = 1 + (k % 4);
      w = 1 + int'($urandom % 6);
      h = 1 + int'($urandom % 6);
      sx = int'($urandom % (SW - w + 1));
      sy = int'($urandom % (SH - h + 1));
      dx = int'($urandom % (SW - w + 1));
      dy = int'($urandom % (SH - h + 1));
      cp = (k % 3) != 0;
      run_op(cp, sx, sy, dx, dy, w, h, $urandom, bp, -1, "random R10", 0);
    end

    summary();
    $finish;
  end
endmodule